// File: doc/BRIEF.md
# Flash Write-Status Word Generator

This block forms the 16-bit word that a NOR-style flash bank returns to the host on a read. With no internal write active, the word is the array data, unchanged. While a program or erase runs, or while an erase is suspended, three bits carry status in place of data. Bit 7 is a polling bit that shows inverted data or an erase level. Bit 6 is a toggle that flips on every status read. Bit 2 is a second toggle, and it moves only for erase activity or for reads that hit the suspended sector or block.

The operation state, the word being programmed, a flag telling whether the read address lies in the suspended region, and the array data all come from the surrounding control logic. A read is signalled by a rising edge of the read strobe. The block samples the strobe on the clock and loads its output register on the first clock edge at which the strobe is seen high. A launch pulse from the command logic clears both toggles when a new program or erase begins.

Top module: `wsg_status_gen`

## Requirements
- R1: After reset, rd_data_o is 0x0000, and the next status read returns 0 on both bit 6 and bit 2.
- R2: With op_i = 0 (idle) or any code above 4, a read returns array_data_i on all 16 bits.
- R3: With op_i = 1 (program), bit 7 of a read is the complement of prog_word_i bit 7. All bits other than 7, 6 and 2 carry array_data_i.
- R4: With op_i = 1, 2 or 4, bit 6 returns the bit-6 toggle state, and that state inverts after every read. The first read after a launch returns 0.
- R5: During a program (op_i = 1 or 4), bit 2 returns the bit-2 toggle state and that state does not change. During an erase (op_i = 2), the bit-2 state inverts after every read.
- R6: With op_i = 2 (erase), bit 7 reads 0.
- R7: With op_i = 3 (erase suspended) and susp_hit_i = 1, a read returns bit 7 = 1, bit 6 = 1 and the bit-2 toggle state, which then inverts. The other bits carry array_data_i.
- R8: With op_i = 3 and susp_hit_i = 0, a read returns array_data_i on all bits and leaves both toggle states unchanged.
- R9: With op_i = 4 (program during suspend), a read returns inverted prog_word_i bit 7 on bit 7, a toggling bit 6 and a steady bit 2, whatever the value of susp_hit_i.
- R10: A one-cycle pulse on launch_i clears both toggle states to 0.
- R11: rd_data_o changes only on the clock edge that first samples rd_strobe_i high after it was low. Holding the strobe high counts as one read, and the output holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation state: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| launch_i | input | 1 | One-cycle pulse when a new program or erase starts |
| prog_word_i | input | 16 | Word being programmed |
| susp_hit_i | input | 1 | Read address lies in the suspended sector or block |
| array_data_i | input | 16 | Data read from the array |
| rd_strobe_i | input | 1 | Read strobe; a rising edge is one read |
| rd_data_o | output | 16 | Read word with status bits substituted |

## Verification
Each read is due one clock edge after the bench raises the strobe. The edge detector and the output register load on the same edge, so the result is visible from that edge until the next read. The driver raises the strobe on a falling edge and queues the expected word. The monitor compares on the next falling edge, half a period after the load. A strobe held over several edges and a later idle interval are checked to confirm that the output moves once only. The toggle states are then examined on the following read.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_SUSP_PROG = 3'd4
  } op_e;
endpackage

// File: rtl/wsg_edge.sv
module wsg_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/wsg_toggle.sv
module wsg_toggle
  import wsg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic rise_i,
  input  op_e  op_i,
  input  logic susp_hit_i,
  output logic tgl6_o,
  output logic tgl2_o
);
  logic flip6, flip2;

  always_comb begin
    flip6 = 1'b0;
    flip2 = 1'b0;
    unique case (op_i)
      OP_PROG, OP_SUSP_PROG: flip6 = rise_i;
      OP_ERASE: begin
        flip6 = rise_i;
        flip2 = rise_i;
      end
      OP_SUSP:  flip2 = rise_i & susp_hit_i;
      default: ;
    endcase
  end

  // launch wins over a coincident read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl6_o <= 1'b0;
      tgl2_o <= 1'b0;
    end else if (launch_i) begin
      tgl6_o <= 1'b0;
      tgl2_o <= 1'b0;
    end else begin
      if (flip6) tgl6_o <= ~tgl6_o;
      if (flip2) tgl2_o <= ~tgl2_o;
    end
  end
endmodule

// File: rtl/wsg_subst.sv
module wsg_subst
  import wsg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int SUSP_BIT = 2
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] prog_word_i,
  input  logic              susp_hit_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              tgl6_i,
  input  logic              tgl2_i,
  output logic [DATA_W-1:0] word_o
);
  logic poll_v, tgl_v, susp_v;

  always_comb begin
    poll_v = array_i[POLL_BIT];
    tgl_v  = array_i[TGL_BIT];
    susp_v = array_i[SUSP_BIT];
    unique case (op_i)
      OP_PROG, OP_SUSP_PROG: begin
        poll_v = ~prog_word_i[POLL_BIT];
        tgl_v  = tgl6_i;
        susp_v = tgl2_i;
      end
      OP_ERASE: begin
        poll_v = 1'b0;
        tgl_v  = tgl6_i;
        susp_v = tgl2_i;
      end
      OP_SUSP: if (susp_hit_i) begin
        poll_v = 1'b1;
        tgl_v  = 1'b1;
        susp_v = tgl2_i;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign word_o[i] = poll_v;
    end else if (i == TGL_BIT) begin : g_tgl
      assign word_o[i] = tgl_v;
    end else if (i == SUSP_BIT) begin : g_susp
      assign word_o[i] = susp_v;
    end else begin : g_pass
      assign word_o[i] = array_i[i];
    end
  end
endmodule

// File: rtl/wsg_status_gen.sv
module wsg_status_gen
  import wsg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6,
  parameter int SUSP_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] prog_word_i,
  input  logic              susp_hit_i,
  input  logic [DATA_W-1:0] array_data_i,
  input  logic              rd_strobe_i,
  output logic [DATA_W-1:0] rd_data_o
);
  op_e               op;
  logic              rise, tgl6, tgl2;
  logic [DATA_W-1:0] word;

  assign op = op_e'(op_i);

  wsg_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (rd_strobe_i),
    .rise_o   (rise)
  );

  wsg_toggle u_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch_i),
    .rise_i     (rise),
    .op_i       (op),
    .susp_hit_i (susp_hit_i),
    .tgl6_o     (tgl6),
    .tgl2_o     (tgl2)
  );

  wsg_subst #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT),
    .SUSP_BIT (SUSP_BIT)
  ) u_subst (
    .op_i        (op),
    .prog_word_i (prog_word_i),
    .susp_hit_i  (susp_hit_i),
    .array_i     (array_data_i),
    .tgl6_i      (tgl6),
    .tgl2_i      (tgl2),
    .word_o      (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_data_o <= '0;
    else if (rise) rd_data_o <= word;
  end
endmodule

// File: rtl/wsg_chk.sv
module wsg_chk #(
  parameter int DATA_W   = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic              susp_hit_i,
  input logic [DATA_W-1:0] prog_word_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic              rd_strobe_i,
  input logic [DATA_W-1:0] rd_data_o
);
  // R2
  idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !$past(rd_strobe_i) && op_i == 3'd0)
      |=> rd_data_o == $past(array_data_i));

  // R3
  prog_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !$past(rd_strobe_i) && op_i == 3'd1)
      |=> rd_data_o[POLL_BIT] == !$past(prog_word_i[POLL_BIT]));

  // R6
  erase_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !$past(rd_strobe_i) && op_i == 3'd2)
      |=> !rd_data_o[POLL_BIT]);

  // R7
  susp_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !$past(rd_strobe_i) && op_i == 3'd3 && susp_hit_i)
      |=> rd_data_o[POLL_BIT] && rd_data_o[TGL_BIT]);

  // R8
  susp_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && !$past(rd_strobe_i) && op_i == 3'd3 && !susp_hit_i)
      |=> rd_data_o == $past(array_data_i));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_i && !$past(rd_strobe_i)) |=> $stable(rd_data_o));
endmodule

bind wsg_status_gen wsg_chk #(
  .DATA_W   (DATA_W),
  .POLL_BIT (POLL_BIT),
  .TGL_BIT  (TGL_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_i         (op_i),
  .susp_hit_i   (susp_hit_i),
  .prog_word_i  (prog_word_i),
  .array_data_i (array_data_i),
  .rd_strobe_i  (rd_strobe_i),
  .rd_data_o    (rd_data_o)
);

// File: tb/wsg_status_gen_bench.sv
module wsg_status_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        launch = 1'b0;
  logic [15:0] pw = '0;
  logic        hit = 1'b0;
  logic [15:0] arr = '0;
  logic        strobe = 1'b0;
  logic [15:0] rd_data;

  int   total = 0;
  int   bad = 0;
  logic due = 1'b0;
  logic done = 1'b0;
  logic m6 = 1'b0;
  logic m2 = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wsg_status_gen u_wsg_status_gen (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .op_i         (op),
    .launch_i     (launch),
    .prog_word_i  (pw),
    .susp_hit_i   (hit),
    .array_data_i (arr),
    .rd_strobe_i  (strobe),
    .rd_data_o    (rd_data)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected word from the requirements, then advance the model toggles
  task automatic push_exp(input string tag);
    logic [15:0] w;
    w = arr;
    case (op)
      3'd1, 3'd4: begin
        w[7] = ~pw[7]; w[6] = m6; w[2] = m2;
        m6 = ~m6;
      end
      3'd2: begin
        w[7] = 1'b0; w[6] = m6; w[2] = m2;
        m6 = ~m6; m2 = ~m2;
      end
      3'd3: if (hit) begin
        w[7] = 1'b1; w[6] = 1'b1; w[2] = m2;
        m2 = ~m2;
      end
      default: ;
    endcase
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [2:0] o, input logic [15:0] p, input logic h,
                    input logic [15:0] a, input string tag);
    @(negedge clk);
    op = o; pw = p; hit = h; arr = a;
    strobe = 1'b1;
    push_exp(tag);
    due <= 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    due <= 1'b0;
  endtask

  task automatic do_launch(input logic [2:0] o);
    @(negedge clk);
    op = o;
    launch = 1'b1;
    @(negedge clk);
    launch = 1'b0;
    m6 = 1'b0;
    m2 = 1'b0;
  endtask

  // monitor: result is due one negedge after the strobe was raised
  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset word", rd_data, 16'h0000);

    // R1: toggles start cleared; R2 idle pass
    rd(3'd0, 16'h0000, 1'b0, 16'hA5C3, "R2 idle");
    rd(3'd6, 16'h0000, 1'b1, 16'h5A3C, "R2 unused code");
    rd(3'd2, 16'h0000, 1'b0, 16'hFFFF, "R1 first erase read");
    rd(3'd0, 16'h0000, 1'b0, 16'h0F0F, "R2 after erase");

    // R3 R4 R5 program
    do_launch(3'd1);
    rd(3'd1, 16'h0080, 1'b0, 16'hFFFF, "R3 program poll");
    rd(3'd1, 16'h0080, 1'b0, 16'hFFFF, "R4 program toggle");
    rd(3'd1, 16'h0000, 1'b0, 16'h1234, "R5 program bit2 steady");
    rd(3'd0, 16'h0000, 1'b0, 16'h00FF, "R2 program done true data");

    // R6 R4 R5 erase
    do_launch(3'd2);
    for (int i = 0; i < 4; i++) rd(3'd2, 16'h0000, 1'b0, 16'hFFFF, "R6 erase status");

    // R7 R8 suspend
    rd(3'd3, 16'h0000, 1'b1, 16'h0000, "R7 suspended hit");
    rd(3'd3, 16'h0000, 1'b1, 16'h0000, "R7 suspended hit bit2");
    rd(3'd3, 16'h0000, 1'b0, 16'h3C3C, "R8 suspended miss");
    rd(3'd3, 16'h0000, 1'b0, 16'hC3C3, "R8 suspended miss again");
    rd(3'd3, 16'h0000, 1'b1, 16'h0000, "R8 bit2 kept across miss");

    // R9 program inside suspend
    do_launch(3'd4);
    rd(3'd4, 16'h0000, 1'b0, 16'h0000, "R9 suspend program");
    rd(3'd4, 16'h0000, 1'b1, 16'h0000, "R9 suspend program hit");
    rd(3'd4, 16'h0080, 1'b0, 16'hFFFF, "R9 suspend program poll");

    // R10 launch clears toggles
    do_launch(3'd2);
    rd(3'd2, 16'h0000, 1'b0, 16'h0000, "R10 erase read a");
    do_launch(3'd2);
    rd(3'd2, 16'h0000, 1'b0, 16'h0000, "R10 erase after relaunch");

    // R11 held strobe counts once, output holds
    @(negedge clk);
    op = 3'd2; arr = 16'h8888; strobe = 1'b1;
    push_exp("R11 held strobe");
    held = exp_q[exp_q.size()-1];
    due <= 1'b1;
    @(negedge clk);
    arr = 16'h7777;
    due <= 1'b0;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    arr = 16'h1111;
    repeat (3) @(negedge clk);
    check("R11 output held", rd_data, held);
    rd(3'd2, 16'h0000, 1'b0, 16'h0000, "R11 single toggle step");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule